// File: doc/BRIEF.md
# Convolutional Symbol Interleaver

This block spreads burst errors across many codewords by passing a stream of symbols through a set of branches. Each branch delays its symbols by a different amount. A commutator assigns every accepted symbol to the next branch in turn and wraps around after the last branch. Branch delays are whole multiples of a unit delay, counted in visits to that branch. A single parameter builds the block either as an interleaver or as the matching deinterleaver. The deinterleaver uses the reversed delay profile, so that a chain of the two gives every symbol the same total delay.

All branch storage sits in one inferred simple dual-port RAM. Each branch owns a contiguous region of that RAM and keeps its own circular offset within it. During a visit, the slot being read is the same slot that receives the new symbol. A resynchronisation pulse steers its own symbol into branch 0, which lets framing symbols always take the same branch. An output flag marks every symbol that left through branch 0. A clock enable gates all state.

Top module: `conv_interleaver`

## Requirements
- R1: While rst_n is low at a clock edge, the next outputs are sym_out = 0 and first_branch = 0, and the commutator restarts at branch 0.
- R2: Each edge with clk_en high moves the commutator from branch k to branch k+1, and from branch BRANCHES-1 back to branch 0. As a result, first_branch is high exactly once every BRANCHES accepted symbols.
- R3: In interleaver mode (DEINT = 0), branch k delays its symbols by k·UNIT_DLY visits. A symbol accepted as stream index n on branch k = n mod BRANCHES therefore leaves at stream index n + k·UNIT_DLY·BRANCHES.
- R4: In deinterleaver mode (DEINT = 1), branch k delays by (BRANCHES-1-k)·UNIT_DLY visits. An interleaver chained into a deinterleaver returns the input stream unchanged, delayed by BRANCHES·UNIT_DLY·(BRANCHES-1) symbols.
- R5: first_branch is high exactly when the current sym_out was produced by a symbol taken on branch 0.
- R6: While clk_en is low, sym_out and first_branch hold their values and no branch pointer or commutator state changes.
- R7: A symbol accepted with resync high goes to branch 0, so first_branch is high for its output. The commutator then continues from branch 1.
- R8: A delayed branch outputs 0 until it has been filled once. This holds after reset and again after a resync, because a resync empties every branch.
- R9: A symbol on the zero-delay branch appears on sym_out one clock edge after it is accepted. Every output is registered once after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Accepts one symbol per edge when high; freezes all state when low |
| resync | input | 1 | With clk_en, sends this symbol to branch 0 and empties every branch |
| sym_in | input | SYM_W | Input symbol |
| sym_out | output | SYM_W | Output symbol |
| first_branch | output | 1 | High when sym_out came from branch 0 |

## Verification
The interleaver is run against an independent history model under two patterns. The first is an incrementing stream with regular clk_en gaps, which separates correct branch stepping from stepping that also happens on idle cycles. The second is a gap-free pseudo-random stream, which exposes wrong slot addressing or a wrong delay multiple. A deinterleaver chained behind the interleaver must return the exact input after the fixed pair delay, and must return zeros before that point. This catches a reversed profile that is wrong or off by one. A resync issued mid-stream checks that every delayed branch returns to zero output and that the resync symbol takes the bypass path.

// File: rtl/il_pkg.sv
// Package il_pkg
// Purpose : shared delay-profile arithmetic for the convolutional interleaver.
// Assumes : branch delays are whole multiples of the unit delay; every
//           function is evaluated at elaboration time only.
package il_pkg;

    // Delay of branch k, in visits to that branch.
    function automatic int unsigned br_delay(input int unsigned k,
                                             input int unsigned n,
                                             input int unsigned unit,
                                             input bit          rev);
        return rev ? (n - 1 - k) * unit : k * unit;
    endfunction

    // First RAM slot of branch k. Equals the sum of all lower branch delays.
    function automatic int unsigned br_base(input int unsigned k,
                                            input int unsigned n,
                                            input int unsigned unit,
                                            input bit          rev);
        int unsigned acc;
        acc = 0;
        for (int unsigned m = 0; m < k; m++) begin
            acc += br_delay(m, n, unit, rev);
        end
        return acc;
    endfunction

endpackage

// File: rtl/il_commutator.sv
// Module  : il_commutator
// Purpose : selects the branch for the symbol offered this cycle and steps
//           to the next branch on every accepted symbol.
// Assumes : resync is only acted on together with clk_en; sel is
//           combinational, so a resync takes effect on its own symbol.
module il_commutator #(
    parameter int unsigned BRANCHES = 12,
    parameter int unsigned BW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          resync,
    output logic [BW-1:0] sel
);
    logic [BW-1:0] pos_q;

    // Branch used by the current symbol: a resync forces branch 0.
    assign sel = resync ? '0 : pos_q;

    // Advance and wrap the stored branch position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clk_en) begin
            pos_q <= (sel == BW'(BRANCHES - 1)) ? '0 : sel + 1'b1;
        end
    end
endmodule

// File: rtl/il_branch_ptrs.sv
// Module  : il_branch_ptrs
// Purpose : keeps one circular offset and one filled flag per delayed
//           branch, and forms the RAM slot address for the selected branch.
// Assumes : each branch k owns slots [base_k, base_k + delay_k) of one RAM;
//           a resync empties every branch before its own symbol is stored.
module il_branch_ptrs
    import il_pkg::*;
#(
    parameter int unsigned BRANCHES = 12,
    parameter int unsigned UNIT_DLY = 17,
    parameter bit          DEINT    = 1'b0,
    parameter int unsigned BW       = 4,
    parameter int unsigned AW       = 11,
    parameter int unsigned PW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          resync,
    input  logic [BW-1:0] sel,
    output logic [AW-1:0] addr,
    output logic          uses_mem,
    output logic          filled
);
    logic [AW-1:0]       base_a  [BRANCHES];
    logic [PW-1:0]       ptr_eff [BRANCHES];
    logic [BRANCHES-1:0] fill_eff;
    logic [BRANCHES-1:0] has_mem;

    for (genvar k = 0; k < BRANCHES; k++) begin : g_br
        localparam int unsigned D = br_delay(k, BRANCHES, UNIT_DLY, DEINT);
        localparam int unsigned B = br_base(k, BRANCHES, UNIT_DLY, DEINT);

        assign base_a[k] = AW'(B);

        if (D > 0) begin : g_mem
            logic [PW-1:0] ptr_q;
            logic          fill_q;
            logic          hit;
            logic [PW-1:0] p_now;
            logic [PW-1:0] p_next;

            assign hit    = clk_en && (sel == BW'(k));
            assign p_now  = resync ? '0 : ptr_q;
            assign p_next = (p_now == PW'(D - 1)) ? '0 : p_now + 1'b1;

            // Step this branch's offset on a visit; a resync empties it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ptr_q  <= '0;
                    fill_q <= 1'b0;
                end else if (hit) begin
                    ptr_q  <= p_next;
                    fill_q <= (fill_q && !resync) || (p_now == PW'(D - 1));
                end else if (clk_en && resync) begin
                    ptr_q  <= '0;
                    fill_q <= 1'b0;
                end
            end

            assign ptr_eff[k]  = p_now;
            assign fill_eff[k] = fill_q && !resync;
            assign has_mem[k]  = 1'b1;
        end else begin : g_pass
            assign ptr_eff[k]  = '0;
            assign fill_eff[k] = 1'b1;
            assign has_mem[k]  = 1'b0;
        end
    end

    // Pick the address and flags of the selected branch.
    always_comb begin
        addr     = '0;
        uses_mem = 1'b0;
        filled   = 1'b0;
        for (int k = 0; k < BRANCHES; k++) begin
            if (sel == BW'(k)) begin
                addr     = base_a[k] + AW'(ptr_eff[k]);
                uses_mem = has_mem[k];
                filled   = fill_eff[k];
            end
        end
    end
endmodule

// File: rtl/il_delay_ram.sv
// Module  : il_delay_ram
// Purpose : simple dual-port storage for all branch delay lines, with a
//           registered read port.
// Assumes : when both ports hit the same address, the read returns the old
//           word (read before write); contents are not reset.
module il_delay_ram #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned WORDS = 1122,
    parameter int unsigned AW    = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read port, returning the old word on a collision.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/conv_interleaver.sv
// Module  : conv_interleaver
// Purpose : convolutional symbol interleaver (DEINT = 0) or deinterleaver
//           (DEINT = 1). Takes one symbol per enabled clock; the output is
//           registered once after the accepting edge.
// Assumes : clk_en gates all state; resync acts only with clk_en high;
//           unfilled branches output zero.
module conv_interleaver
    import il_pkg::*;
#(
    parameter int unsigned SYM_W    = 8,
    parameter int unsigned BRANCHES = 12,
    parameter int unsigned UNIT_DLY = 17,
    parameter bit          DEINT    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             resync,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] sym_out,
    output logic             first_branch
);
    localparam int unsigned TOTAL = br_base(BRANCHES, BRANCHES, UNIT_DLY, DEINT);
    localparam int unsigned WORDS = (TOTAL > 0) ? TOTAL : 1;
    localparam int unsigned AW    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int unsigned MAXD  = (BRANCHES - 1) * UNIT_DLY;
    localparam int unsigned PW    = (MAXD > 1) ? $clog2(MAXD + 1) : 1;
    localparam int unsigned BW    = (BRANCHES > 1) ? $clog2(BRANCHES) : 1;

    logic [BW-1:0]    sel;
    logic [AW-1:0]    addr;
    logic             uses_mem;
    logic             filled;
    logic [SYM_W-1:0] rd_data;
    logic [SYM_W-1:0] byp_q;
    logic             pass_q;
    logic             fill_q;
    logic             first_q;

    il_commutator #(.BRANCHES(BRANCHES), .BW(BW)) u_comm (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .resync (resync),
        .sel    (sel)
    );

    il_branch_ptrs #(
        .BRANCHES (BRANCHES),
        .UNIT_DLY (UNIT_DLY),
        .DEINT    (DEINT),
        .BW       (BW),
        .AW       (AW),
        .PW       (PW)
    ) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .resync   (resync),
        .sel      (sel),
        .addr     (addr),
        .uses_mem (uses_mem),
        .filled   (filled)
    );

    il_delay_ram #(.WIDTH(SYM_W), .WORDS(WORDS), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (clk_en && uses_mem),
        .waddr (addr),
        .wdata (sym_in),
        .re    (clk_en && uses_mem),
        .raddr (addr),
        .rdata (rd_data)
    );

    // Register the bypass symbol and the selectors for the output mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q   <= '0;
            pass_q  <= 1'b0;
            fill_q  <= 1'b0;
            first_q <= 1'b0;
        end else if (clk_en) begin
            byp_q   <= sym_in;
            pass_q  <= !uses_mem;
            fill_q  <= filled;
            first_q <= (sel == '0);
        end
    end

    assign sym_out      = pass_q ? byp_q : (fill_q ? rd_data : '0);
    assign first_branch = first_q;
endmodule

// File: rtl/il_checker.sv
// Module  : il_checker
// Purpose : temporal properties of conv_interleaver, attached with bind.
// Assumes : sel is the commutator's branch choice inside the top module.
module il_checker #(
    parameter int unsigned SYM_W    = 8,
    parameter int unsigned BRANCHES = 12,
    parameter int unsigned BW       = 4,
    parameter bit          DEINT    = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             resync,
    input logic [SYM_W-1:0] sym_in,
    input logic [SYM_W-1:0] sym_out,
    input logic             first_branch,
    input logic [BW-1:0]    sel
);
    localparam int unsigned ZB = DEINT ? BRANCHES - 1 : 0;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sym_out == '0 && !first_branch));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && sel != BW'(BRANCHES - 1) |=> resync || sel == $past(sel) + 1'b1);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && sel == BW'(BRANCHES - 1) |=> sel == '0);

    p_first_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> first_branch == ($past(sel) == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(sym_out) && $stable(first_branch));

    p_resync_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && resync |=> first_branch);

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && sel == BW'(ZB) |=> sym_out == $past(sym_in));
endmodule

bind conv_interleaver il_checker #(
    .SYM_W    (SYM_W),
    .BRANCHES (BRANCHES),
    .BW       (BW),
    .DEINT    (DEINT)
) u_il_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_en       (clk_en),
    .resync       (resync),
    .sym_in       (sym_in),
    .sym_out      (sym_out),
    .first_branch (first_branch),
    .sel          (sel)
);

// File: tb/tb_conv_interleaver.sv
// Scoreboard bench: an interleaver (dut) is checked against a history
// model, and is chained into a deinterleaver whose output is compared
// against a queue of accepted input symbols.
module tb_conv_interleaver;
    localparam int CLK_P = 10;
    localparam int I     = 12;
    localparam int J     = 17;
    localparam int W     = 8;
    localparam int DPAIR = I * J * (I - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_r = 1'b0, rs_r = 1'b0;
    logic         en_d = 1'b0, rs_d = 1'b0;
    logic [W-1:0] sym_r = '0;
    logic [W-1:0] il_out, dl_out;
    logic         il_fb, dl_fb;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] hist [0:16383];
    int  widx = 0;
    bit  chain_on = 1'b0;
    bit  mon_on = 1'b0;
    logic [W-1:0] expq [$];

    always #(CLK_P / 2) clk = ~clk;

    conv_interleaver #(.SYM_W(W), .BRANCHES(I), .UNIT_DLY(J), .DEINT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(en_r), .resync(rs_r),
        .sym_in(sym_r), .sym_out(il_out), .first_branch(il_fb));

    conv_interleaver #(.SYM_W(W), .BRANCHES(I), .UNIT_DLY(J), .DEINT(1'b1)) u_deint (
        .clk(clk), .rst_n(rst_n), .clk_en(en_d), .resync(rs_d),
        .sym_in(il_out), .sym_out(dl_out), .first_branch(dl_fb));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one symbol slot per call, applied at the falling edge.
    task automatic send(input logic [W-1:0] d, input logic en, input logic rs);
        @(negedge clk);
        en_d  = en_r;
        rs_d  = rs_r;
        en_r  = en;
        rs_r  = rs;
        sym_r = d;
        if (en) begin
            if (rs) widx = 0;
            hist[widx] = d;
            widx++;
            if (chain_on) expq.push_back(d);
        end
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        int didx = 0, m = 0, b, lag;
        logic [W-1:0] exp, prev_out;
        logic prev_fb;
        prev_out = '0;
        prev_fb  = 1'b0;
        forever begin
            @(posedge clk);
            #(CLK_P / 4);
            if (mon_on) begin
                if (en_r) begin
                    if (rs_r) begin
                        didx = 0;
                        chk(il_fb == 1'b1 && il_out == sym_r, "R7", {il_fb, il_out}, {1'b1, sym_r});
                    end
                    b   = didx % I;
                    lag = b * I * J;
                    exp = (didx >= lag) ? hist[didx - lag] : '0;
                    if (b == 0)
                        chk(il_out == exp, "R9", il_out, exp);
                    else if (didx < lag)
                        chk(il_out == exp, "R8", il_out, exp);
                    else
                        chk(il_out == exp, "R3", il_out, exp);
                    chk(il_fb == (b == 0), "R2/R5", il_fb, (b == 0));
                    didx++;
                end else begin
                    chk(il_out == prev_out && il_fb == prev_fb, "R6",
                        {il_fb, il_out}, {prev_fb, prev_out});
                end
                if (en_d && chain_on) begin
                    if (m < DPAIR) exp = '0;
                    else           exp = expq.pop_front();
                    chk(dl_out == exp, "R4", dl_out, exp);
                    m++;
                end
            end
            prev_out = il_out;
            prev_fb  = il_fb;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Stimulus.
    initial begin
        logic [7:0] lf;
        repeat (5) @(negedge clk);
        // R1: outputs cleared while in reset.
        chk(il_out == '0 && !il_fb, "R1", {il_fb, il_out}, 0);
        chk(dl_out == '0 && !dl_fb, "R1", {dl_fb, dl_out}, 0);
        rst_n    = 1'b1;
        mon_on   = 1'b1;
        chain_on = 1'b1;
        // Pattern 1: incrementing data with periodic clk_en gaps.
        send(8'h01, 1'b1, 1'b1);
        for (int i = 1; i < 3000; i++) begin
            if (i % 5 == 0) send(8'hAA, 1'b0, 1'b0);
            send(8'(i + 1), 1'b1, 1'b0);
        end
        // Pattern 2: pseudo-random data, no gaps.
        lf = 8'h1;
        for (int i = 0; i < 2600; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            send(lf, 1'b1, 1'b0);
        end
        // Pattern 3: resync mid-stream empties all branches.
        chain_on = 1'b0;
        send(8'h00, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        send(8'h5A, 1'b1, 1'b1);
        for (int i = 0; i < 300; i++) send(8'(i * 3 + 7), 1'b1, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b0);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule